// File: doc/BRIEF.md
# Write-Selected ROM Bank Mapper

This block sits on the cartridge side of an 8-bit CPU bus with a 64KB address space. It gives a 256KB ROM to that bus. Each 16KB quarter of the CPU map is a region. The region picked by the `WIN_REGION` parameter is a switchable window that can show any of the ROM's 16KB banks. The other regions map to a fixed bank. That bank is the region's own number, so the first two regions always show banks 0 and 1.

The window has no separate control address. When the CPU writes a byte anywhere inside the window, the low data nibble is taken as the new bank number on the next clock edge. Only the two top address bits and the chip enable take part in the decode. The block also produces the active-low ROM enable. That enable is active for the lower three regions and inactive for the top region, which the cartridge leaves to the rest of the system.

Top module: `rbm_mapper`

## Requirements
- R1: A synchronous reset (active high) sets the bank register to `RESET_BANK` (default 2). After reset, an access to the window drives the physical ROM lines A17..A14 to 0010.
- R2: For CPU addresses 0x0000-0x3FFF (A15=0, A14=0), the outputs A17..A14 are 0000. This holds whatever bank is loaded.
- R3: For CPU addresses 0x4000-0x7FFF (A15=0, A14=1), the outputs A17..A14 are 0001. This holds whatever bank is loaded.
- R4: For CPU addresses 0x8000-0xBFFF (A15=1, A14=0), the outputs A17..A14 equal the bank register. They are combinational from the address and the register.
- R5: A write loads data bits D3..D0 into the bank register at the rising clock edge. A write here means write strobe low and chip enable low, with the address in 0x8000-0xBFFF. Before that edge the outputs still show the old bank. After the edge they show the new bank.
- R6: A write with the address in 0x0000-0x7FFF or 0xC000-0xFFFF leaves the bank register unchanged.
- R7: A write into the window while the chip enable is high leaves the bank register unchanged.
- R8: A read (write strobe high) into the window leaves the bank register unchanged, for any number of cycles.
- R9: The ROM enable output is low exactly when the chip enable is low and the address is below 0xC000.
- R10: Each of the 16 bank values 0..15 can be loaded and then read back through the window outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the bank register loads on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpu_a15 | input | 1 | CPU address bit 15 |
| cpu_a14 | input | 1 | CPU address bit 14 |
| cpu_ce_n | input | 1 | CPU chip enable, active low |
| cpu_wr_n | input | 1 | CPU write strobe, active low |
| cpu_d | input | BANK_W | CPU data bits D3..D0 |
| rom_a | output | BANK_W | Physical ROM address lines A17..A14 |
| rom_ce_n | output | 1 | ROM enable, active low |

## Verification
The bench builds the block with its default parameters. These are a 4-bit bank register, the window in region 2, and a reset bank of 2. With these values all 16 bank codes can be reached in a short directed run. The two fixed regions can be compared against the window for every loaded value. A 4-bit data pattern that differs from the resident bank shows any write that leaks through from outside the window, from a disabled chip enable, or from a read. The top region is unmapped under these defaults, so writes there and the ROM enable decode can also be exercised.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
   // The CPU map is split by its two top address bits.
   localparam int REGION_BITS = 2;
   localparam int NUM_REGIONS = 1 << REGION_BITS;
   // The highest region is never served by the ROM.
   localparam int UNMAPPED_REGION = NUM_REGIONS - 1;

   typedef logic [REGION_BITS-1:0] region_t;

   function automatic region_t to_region(input logic a15, input logic a14);
      return {a15, a14};
   endfunction
endpackage

// File: rtl/rbm_region_decode.sv
module rbm_region_decode
   import rbm_pkg::*;
#(
   parameter int WIN_REGION = 2
) (
   input  logic    cpu_a15,
   input  logic    cpu_a14,
   input  logic    cpu_ce_n,
   input  logic    cpu_wr_n,
   output region_t region,
   output logic    load_en,
   output logic    rom_ce_n
);
   localparam region_t WIN_CODE  = region_t'(WIN_REGION);
   localparam region_t HOLE_CODE = region_t'(UNMAPPED_REGION);

   logic in_window;

   always_comb begin
      region    = to_region(cpu_a15, cpu_a14);
      in_window = (region == WIN_CODE);
      // Any write into the window selects a bank; low address bits are ignored.
      load_en   = !cpu_ce_n && !cpu_wr_n && in_window;
      rom_ce_n  = cpu_ce_n || (region == HOLE_CODE);
   end
endmodule

// File: rtl/rbm_bank_reg.sv
module rbm_bank_reg #(
   parameter int BANK_W     = 4,
   parameter int RESET_BANK = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_en,
   input  logic [BANK_W-1:0] d,
   output logic [BANK_W-1:0] q
);
   localparam logic [BANK_W-1:0] RST_VAL = BANK_W'(RESET_BANK);

   always_ff @(posedge clk) begin
      if (rst)          q <= RST_VAL;
      else if (load_en) q <= d;
   end
endmodule

// File: rtl/rbm_addr_mux.sv
module rbm_addr_mux
   import rbm_pkg::*;
#(
   parameter int BANK_W     = 4,
   parameter int WIN_REGION = 2
) (
   input  region_t           region,
   input  logic [BANK_W-1:0] bank_q,
   output logic [BANK_W-1:0] rom_a
);
   logic [BANK_W-1:0] region_bank [NUM_REGIONS];

   // Each region maps to its own bank number, except the window.
   for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
      if (r == WIN_REGION) begin : g_win
         assign region_bank[r] = bank_q;
      end else begin : g_fixed
         assign region_bank[r] = BANK_W'(r);
      end
   end

   assign rom_a = region_bank[region];
endmodule

// File: rtl/rbm_mapper.sv
module rbm_mapper
   import rbm_pkg::*;
#(
   parameter int BANK_W     = 4,
   parameter int RESET_BANK = 2,
   parameter int WIN_REGION = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cpu_a15,
   input  logic              cpu_a14,
   input  logic              cpu_ce_n,
   input  logic              cpu_wr_n,
   input  logic [BANK_W-1:0] cpu_d,
   output logic [BANK_W-1:0] rom_a,
   output logic              rom_ce_n
);
   localparam int NUM_BANKS = 1 << BANK_W;

   if (BANK_W < REGION_BITS || BANK_W > 8) begin : g_bad_width
      $fatal(1, "BANK_W must lie between REGION_BITS and 8");
   end
   if (RESET_BANK < 0 || RESET_BANK >= NUM_BANKS) begin : g_bad_reset
      $fatal(1, "RESET_BANK outside the bank range");
   end
   if (WIN_REGION < 0 || WIN_REGION >= UNMAPPED_REGION) begin : g_bad_window
      $fatal(1, "WIN_REGION must be a ROM-backed region");
   end

   region_t           region;
   logic              load_en;
   logic [BANK_W-1:0] bank_q;

   rbm_region_decode #(.WIN_REGION(WIN_REGION)) u_dec (
      .cpu_a15 (cpu_a15),
      .cpu_a14 (cpu_a14),
      .cpu_ce_n(cpu_ce_n),
      .cpu_wr_n(cpu_wr_n),
      .region  (region),
      .load_en (load_en),
      .rom_ce_n(rom_ce_n)
   );

   rbm_bank_reg #(.BANK_W(BANK_W), .RESET_BANK(RESET_BANK)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .load_en(load_en),
      .d      (cpu_d),
      .q      (bank_q)
   );

   rbm_addr_mux #(.BANK_W(BANK_W), .WIN_REGION(WIN_REGION)) u_mux (
      .region(region),
      .bank_q(bank_q),
      .rom_a (rom_a)
   );
endmodule

// File: rtl/rbm_mapper_chk.sv
module rbm_mapper_chk #(
   parameter int BANK_W     = 4,
   parameter int RESET_BANK = 2,
   parameter int WIN_REGION = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              cpu_a15,
   input logic              cpu_a14,
   input logic              cpu_ce_n,
   input logic              cpu_wr_n,
   input logic [BANK_W-1:0] cpu_d,
   input logic [BANK_W-1:0] rom_a,
   input logic              rom_ce_n,
   input logic [BANK_W-1:0] bank_q
);
   localparam logic [1:0] WIN = 2'(WIN_REGION);
   localparam logic [BANK_W-1:0] RST_VAL = BANK_W'(RESET_BANK);

   logic [1:0] reg_sel;
   logic       wr_win;
   assign reg_sel = {cpu_a15, cpu_a14};
   assign wr_win  = !cpu_ce_n && !cpu_wr_n && (reg_sel == WIN);

   // R1
   p_reset_bank_r1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> bank_q == RST_VAL);
   // R2 and R3: fixed regions show their own bank number
   p_fixed_map_r2: assert property (@(posedge clk) disable iff (rst)
      (reg_sel != WIN) |-> rom_a == BANK_W'(reg_sel));
   // R4
   p_window_map_r4: assert property (@(posedge clk) disable iff (rst)
      (reg_sel == WIN) |-> rom_a == bank_q);
   // R5
   p_load_r5: assert property (@(posedge clk) disable iff (rst)
      wr_win |=> bank_q == $past(cpu_d));
   // R6, R7, R8: anything other than a window write keeps the bank
   p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !wr_win |=> $stable(bank_q));
   // R9
   p_rom_on_r9: assert property (@(posedge clk) disable iff (rst)
      (!cpu_ce_n && !(cpu_a15 && cpu_a14)) |-> !rom_ce_n);
   p_rom_off_r9: assert property (@(posedge clk) disable iff (rst)
      (cpu_ce_n || (cpu_a15 && cpu_a14)) |-> rom_ce_n);
endmodule

bind rbm_mapper rbm_mapper_chk #(
   .BANK_W(BANK_W), .RESET_BANK(RESET_BANK), .WIN_REGION(WIN_REGION)
) u_chk (
   .clk(clk), .rst(rst), .cpu_a15(cpu_a15), .cpu_a14(cpu_a14),
   .cpu_ce_n(cpu_ce_n), .cpu_wr_n(cpu_wr_n), .cpu_d(cpu_d),
   .rom_a(rom_a), .rom_ce_n(rom_ce_n), .bank_q(bank_q)
);

// File: tb/tb_rbm_mapper.sv
`timescale 1ns/1ps
module tb_rbm_mapper;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       a15 = 1'b0, a14 = 1'b0, ce_n = 1'b1, wr_n = 1'b1;
   logic [3:0] d = 4'h0;
   logic [3:0] rom_a;
   logic       rom_ce_n;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   rbm_mapper dut (
      .clk(clk), .rst(rst), .cpu_a15(a15), .cpu_a14(a14),
      .cpu_ce_n(ce_n), .cpu_wr_n(wr_n), .cpu_d(d),
      .rom_a(rom_a), .rom_ce_n(rom_ce_n)
   );

   task automatic check4(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: rom_a actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check1(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: rom_ce_n actual %b expected %b", req, act, exp);
      end
   endtask

   // Read-style look at a region, sampled mid-cycle
   task automatic peek(input logic [1:0] reg_sel);
      @(negedge clk);
      {a15, a14} = reg_sel; ce_n = 1'b0; wr_n = 1'b1;
      #1;
   endtask

   task automatic bus_write(input logic [1:0] reg_sel, input logic cen, input logic [3:0] val);
      @(negedge clk);
      {a15, a14} = reg_sel; ce_n = cen; wr_n = 1'b0; d = val;
      @(posedge clk);
      #1;
      @(negedge clk);
      wr_n = 1'b1; ce_n = 1'b1; d = ~val;
   endtask

   task automatic t_reset;
      peek(2'b10);
      check4("R1", rom_a, 4'd2);
   endtask

   task automatic t_fixed(input logic [3:0] resident);
      peek(2'b00); check4("R2", rom_a, 4'd0);
      peek(2'b01); check4("R3", rom_a, 4'd1);
      peek(2'b10); check4("R4", rom_a, resident);
   endtask

   task automatic t_load_timing;
      @(negedge clk);
      {a15, a14} = 2'b10; ce_n = 1'b0; wr_n = 1'b0; d = 4'd9;
      #1 check4("R5 before edge", rom_a, 4'd2);
      @(posedge clk);
      #1 check4("R5 after edge", rom_a, 4'd9);
      @(negedge clk);
      wr_n = 1'b1; ce_n = 1'b1;
   endtask

   task automatic t_all_banks;
      for (int b = 0; b < 16; b++) begin
         bus_write(2'b10, 1'b0, 4'(b));
         peek(2'b10);
         check4("R10", rom_a, 4'(b));
      end
   endtask

   task automatic t_outside;
      bus_write(2'b10, 1'b0, 4'd5);
      bus_write(2'b00, 1'b0, 4'd12);
      peek(2'b10); check4("R6 region0", rom_a, 4'd5);
      bus_write(2'b01, 1'b0, 4'd12);
      peek(2'b10); check4("R6 region1", rom_a, 4'd5);
      bus_write(2'b11, 1'b0, 4'd12);
      peek(2'b10); check4("R6 region3", rom_a, 4'd5);
   endtask

   task automatic t_ce_off;
      bus_write(2'b10, 1'b1, 4'd10);
      peek(2'b10); check4("R7", rom_a, 4'd5);
   endtask

   task automatic t_read;
      @(negedge clk);
      {a15, a14} = 2'b10; ce_n = 1'b0; wr_n = 1'b1; d = 4'd7;
      repeat (4) @(posedge clk);
      #1 check4("R8", rom_a, 4'd5);
   endtask

   task automatic t_rom_ce;
      for (int r = 0; r < 4; r++) begin
         @(negedge clk);
         {a15, a14} = 2'(r); wr_n = 1'b1; ce_n = 1'b0;
         #1 check1("R9 ce low", rom_ce_n, (r == 3));
         ce_n = 1'b1;
         #1 check1("R9 ce high", rom_ce_n, 1'b1);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst = 1'b0;
      t_reset();
      t_fixed(4'd2);
      t_load_timing();
      t_fixed(4'd9);
      t_all_banks();
      t_fixed(4'd15);
      t_outside();
      t_ce_off();
      t_read();
      t_rom_ce();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule